// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog for a small microcontroller. Once software enables it, a counter runs on every clock. When the count reaches the period picked by a two-bit select, the block sets a time-out flag. If the interrupt enable input and the global enable input are both high, the flag raises an interrupt request. The same time-out opens a grace window of 512 clocks. If reset generation is enabled and software has not restarted the counter by the end of that window, the block emits a one-clock system reset pulse and records the cause in a sticky flag.

Software reaches all control and status bits through one seven-bit register word: a write strobe with write data, and a read-data bus that always shows the current state. Two synchronous reset inputs separate a power-fail reset, which disables the watchdog, from any other system reset, which only restarts the count. A parameter shortens the four periods so that simulation can reach all of them.

Top module: `wdt_two_stage`

Register word layout. Bit 0 is run enable. Bit 1 is reset enable. Bit 2 is restart: write 1 to restart; it always reads 0. Bit 3 is the time-out flag. Bit 4 is the reset-cause flag. Bits 6:5 are the period select. For both flags, writing 0 clears the flag and writing 1 leaves it unchanged. A write loads run enable, reset enable and select directly.

## Requirements
- R1: After the asynchronous power-on reset every register bit reads 0, and `irq_o` and `wdt_rst_o` are low.
- R2: With run enable at 1, the time-out flag rises exactly P clocks after the edge that accepts a restart write. P is 2^(17+3*s-SCALE_SHIFT) for select value s (0 to 3). The counter then restarts on its own, so time-outs repeat every P clocks.
- R3: Writing 1 to bit 2 clears the counter and the grace window. Bit 2 always reads 0. A restart inside the grace window prevents the reset pulse.
- R4: `irq_o` is high exactly when the time-out flag, `irq_en_i` and `gie_i` are all high.
- R5: With reset enable at 1 and no restart, `wdt_rst_o` goes high for exactly one clock, 512 clocks after the flag rose.
- R6: The watchdog's own reset sets the reset-cause flag, clears the time-out flag and restarts the counter from zero. Run enable, reset enable and select are kept.
- R7: With reset enable at 0, no pulse is produced and the reset-cause flag is never set. The counter keeps running and keeps setting the time-out flag.
- R8: Writing 0 to a flag bit clears that flag, and writing 1 has no effect. If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R9: A pulse on `ext_rst_i` clears the time-out flag, the counter and the grace window. It keeps the control bits and the reset-cause flag.
- R10: A pulse on `pfail_rst_i` clears every register bit, which disables the watchdog. No flag or pulse follows.
- R11: Changing the select while the counter runs keeps the count. If the count already meets the new period, the time-out occurs on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pfail_rst_i | input | 1 | Synchronous power-fail reset; disables the watchdog |
| ext_rst_i | input | 1 | Synchronous non-power reset; restarts the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 7 | Register write data |
| rd_data_o | output | 7 | Register read data |
| irq_en_i | input | 1 | Watchdog interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| wdt_rst_o | output | 1 | One-clock system reset request |

## Verification
The assertions assume that the reset inputs and the write strobe are synchronous single-cycle events. They also assume that no power-fail and other reset share a cycle with a register write whose effect a property relies on. The stimulus issues every write, reset and gating change alone, a few cycles after a rising edge. It spaces the events so that each one lands on a known edge relative to the last restart. The one deliberate collision, a software flag clear on the exact edge of a time-out, is placed by counting clocks from a restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W    = 2;
  localparam int NUM_SEL  = 1 << SEL_W;
  localparam int BASE_EXP = 17;
  localparam int EXP_STEP = 3;
  localparam int MAX_EXP  = BASE_EXP + EXP_STEP * (NUM_SEL - 1);
  localparam int REG_W    = 7;

  localparam int F_RUN   = 0;
  localparam int F_RSTEN = 1;
  localparam int F_KICK  = 2;
  localparam int F_TMO   = 3;
  localparam int F_CAUSE = 4;
  localparam int F_SEL   = 5;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             cause;
    logic             tmo;
    logic             kick;
    logic             rst_en;
    logic             run;
  } wdt_reg_t;

  function automatic int sel_exp(int code, int shift);
    return BASE_EXP + EXP_STEP * code - shift;
  endfunction
endpackage

// File: rtl/wdt_period_counter.sv
module wdt_period_counter
  import wdt_pkg::*;
#(
  parameter int SCALE_SHIFT = 0,
  parameter int CNT_W       = MAX_EXP - SCALE_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             timeout_o
);
  logic [CNT_W-1:0] lim_tab [NUM_SEL];
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    localparam int EXP = sel_exp(g, SCALE_SHIFT);
    localparam logic [CNT_W-1:0] LIM = CNT_W'((64'd1 << EXP) - 64'd1);
    assign lim_tab[g] = LIM;
  end

  // >= so a shorter select applied late still fires on the next clock
  assign timeout_o = run_i && !clear_i && (cnt_q >= lim_tab[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || clear_i)   cnt_q <= '0;
    else if (timeout_o)           cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_grace_window.sv
module wdt_grace_window #(
  parameter int GRACE_CYCLES = 512,
  parameter int GW           = $clog2(GRACE_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  input  logic rst_en_i,
  input  logic timeout_i,
  output logic expire_o,
  output logic pulse_o
);
  localparam logic [GW-1:0] LAST = GW'(GRACE_CYCLES - 1);

  logic          act_q;
  logic [GW-1:0] gcnt_q;
  logic          win_end;
  logic          pulse_q;

  assign win_end  = act_q && (gcnt_q == LAST);
  assign expire_o = win_end && rst_en_i && run_i && !clear_i;
  assign pulse_o  = pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      gcnt_q <= '0;
    end else if (clear_i || !run_i || win_end) begin
      act_q  <= 1'b0;
      gcnt_q <= '0;
    end else if (act_q) begin
      gcnt_q <= gcnt_q + 1'b1;
    end else if (timeout_i) begin
      // a later time-out inside an open window does not reopen it
      act_q  <= 1'b1;
      gcnt_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= expire_o;
  end
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pfail_i,
  input  logic             ext_rst_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             timeout_i,
  input  logic             expire_i,
  output logic             run_o,
  output logic             rst_en_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             kick_o,
  output logic [REG_W-1:0] rd_data_o
);
  wdt_reg_t wr;
  wdt_reg_t rd;
  logic run_q, rst_en_q, tmo_q, cause_q;
  logic [SEL_W-1:0] sel_q;

  assign wr     = wdt_reg_t'(wr_data_i);
  assign kick_o = wr_en_i && wr.kick && !pfail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      rst_en_q <= 1'b0;
      sel_q    <= '0;
    end else if (pfail_i) begin
      run_q    <= 1'b0;
      rst_en_q <= 1'b0;
      sel_q    <= '0;
    end else if (wr_en_i) begin
      run_q    <= wr.run;
      rst_en_q <= wr.rst_en;
      sel_q    <= wr.sel;
    end
  end

  // hardware set > any reset clear > software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tmo_q <= 1'b0;
    else if (pfail_i)                   tmo_q <= 1'b0;
    else if (timeout_i)                 tmo_q <= 1'b1;
    else if (ext_rst_i || expire_i)     tmo_q <= 1'b0;
    else if (wr_en_i && !wr.tmo)        tmo_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cause_q <= 1'b0;
    else if (pfail_i)                   cause_q <= 1'b0;
    else if (expire_i)                  cause_q <= 1'b1;
    else if (wr_en_i && !wr.cause)      cause_q <= 1'b0;
  end

  always_comb begin
    rd        = '0;
    rd.run    = run_q;
    rd.rst_en = rst_en_q;
    rd.tmo    = tmo_q;
    rd.cause  = cause_q;
    rd.sel    = sel_q;
  end

  assign rd_data_o = rd;
  assign run_o     = run_q;
  assign rst_en_o  = rst_en_q;
  assign sel_o     = sel_q;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int SCALE_SHIFT  = 0,
  parameter int GRACE_CYCLES = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pfail_rst_i,
  input  logic             ext_rst_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             irq_en_i,
  input  logic             gie_i,
  output logic             irq_o,
  output logic             wdt_rst_o
);
  localparam int CNT_W = MAX_EXP - SCALE_SHIFT;

  logic             run, rst_en, kick, timeout, expire;
  logic             clr_base, clr_cnt;
  logic [SEL_W-1:0] sel;

  assign clr_base = kick || ext_rst_i || pfail_rst_i;
  assign clr_cnt  = clr_base || expire;

  wdt_ctrl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pfail_i   (pfail_rst_i),
    .ext_rst_i (ext_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .timeout_i (timeout),
    .expire_i  (expire),
    .run_o     (run),
    .rst_en_o  (rst_en),
    .sel_o     (sel),
    .kick_o    (kick),
    .rd_data_o (rd_data_o)
  );

  wdt_period_counter #(
    .SCALE_SHIFT (SCALE_SHIFT),
    .CNT_W       (CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .clear_i   (clr_cnt),
    .sel_i     (sel),
    .timeout_o (timeout)
  );

  wdt_grace_window #(
    .GRACE_CYCLES (GRACE_CYCLES)
  ) u_grace (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .clear_i   (clr_base),
    .rst_en_i  (rst_en),
    .timeout_i (timeout),
    .expire_o  (expire),
    .pulse_o   (wdt_rst_o)
  );

  assign irq_o = rd_data_o[F_TMO] && irq_en_i && gie_i;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk
  import wdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pfail_rst_i,
  input logic             ext_rst_i,
  input logic             kick_wr_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o,
  input logic             wdt_rst_o
);
  // R4
  assert_irq_needs_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rd_data_o[F_TMO]);

  // R5
  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  // R5
  assert_pulse_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(rd_data_o[F_RSTEN]));

  // R6
  assert_pulse_sets_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> rd_data_o[F_CAUSE]);

  // R7
  assert_no_cause_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[F_RSTEN] |=> !$rose(rd_data_o[F_CAUSE]));

  // R3
  assert_kick_blocks_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_wr_i |=> !wdt_rst_o);

  // R9
  assert_ext_clears_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_i && !pfail_rst_i) |=> !rd_data_o[F_TMO]);

  // R10
  assert_pfail_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfail_rst_i |=> (rd_data_o == '0));
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pfail_rst_i (pfail_rst_i),
  .ext_rst_i   (ext_rst_i),
  .kick_wr_i   (wr_en_i && wr_data_i[wdt_pkg::F_KICK]),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .wdt_rst_o   (wdt_rst_o)
);

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
  localparam int SHIFT = 10;
  localparam int GRACE = 512;

  // observed quantity codes
  localparam int K_RST = 0, K_TMO = 1, K_CAUSE = 2, K_IRQ = 3, K_WORD = 4, K_RUN = 5;

  logic       clk = 1'b0;
  logic       rst_n, pfail, ext, wr_en, irq_en, gie;
  logic [6:0] wr_data;
  logic [6:0] rd_data;
  logic       irq, wdt_rst;

  always #10 clk = ~clk;

  wdt_two_stage #(.SCALE_SHIFT(SHIFT), .GRACE_CYCLES(GRACE)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pfail_rst_i (pfail),
    .ext_rst_i   (ext),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .irq_en_i    (irq_en),
    .gie_i       (gie),
    .irq_o       (irq),
    .wdt_rst_o   (wdt_rst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    int    kind;
    int    exp;
    string tag;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    fails  = 0;
  bit    finished = 1'b0;

  function automatic int per(int s);
    return 1 << (17 + 3 * s - SHIFT);
  endfunction

  // layout: [6:5] sel, [4] cause, [3] tmo, [2] restart, [1] reset enable, [0] run
  function automatic logic [6:0] word(int sel, logic cause, logic tmo, logic kick,
                                      logic rsten, logic run);
    return {2'(sel), cause, tmo, kick, rsten, run};
  endfunction

  function automatic int observe(int kind);
    case (kind)
      K_RST:   return int'(wdt_rst);
      K_TMO:   return int'(rd_data[3]);
      K_CAUSE: return int'(rd_data[4]);
      K_IRQ:   return int'(irq);
      K_WORD:  return int'(rd_data);
      default: return int'(rd_data[0]);
    endcase
  endfunction

  // monitor: scoreboard items are compared at the falling edge of their cycle
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      int act;
      if (sbq[i].due <= cyc) begin
        act = observe(sbq[i].kind);
        checks++;
        if (sbq[i].due < cyc || act != sbq[i].exp) begin
          fails++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                   sbq[i].tag, sbq[i].kind, cyc, act, sbq[i].exp);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic expect_at(int due, int kind, int exp, string tag);
    sbq.push_back('{due, kind, exp, tag});
  endtask

  task automatic wait_edge(int e);
    while (cyc < e - 1) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic write_at(int e, logic [6:0] d);
    wait_edge(e);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    #2;
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic ext_at(int e);
    wait_edge(e);
    ext = 1'b1;
    @(posedge clk);
    #2;
    ext = 1'b0;
  endtask

  task automatic pfail_at(int e);
    wait_edge(e);
    pfail = 1'b1;
    @(posedge clk);
    #2;
    pfail = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int k0, k1, k, e, p, q;
    rst_n = 1'b0; pfail = 1'b0; ext = 1'b0; wr_en = 1'b0; wr_data = '0;
    irq_en = 1'b1; gie = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    expect_at(cyc, K_WORD, 0, "R1");
    expect_at(cyc, K_RST,  0, "R1");
    expect_at(cyc, K_IRQ,  0, "R1");

    // code 00, reset generation off
    k0 = cyc + 5;
    expect_at(k0,       K_WORD,  1, "R3 restart reads 0 / R8 write-1 keeps flag");
    expect_at(k0 + 127, K_TMO,   0, "R2 code00");
    expect_at(k0 + 128, K_TMO,   1, "R2 code00");
    expect_at(k0 + 128, K_IRQ,   1, "R4");
    expect_at(k0 + 128 + GRACE, K_RST,   0, "R7");
    expect_at(k0 + 128 + GRACE, K_CAUSE, 0, "R7");
    expect_at(k0 + 256, K_TMO,   1, "R7 periodic flag");
    write_at(k0, word(0, 1, 1, 1, 0, 1));

    wait_edge(k0 + 200);
    gie = 1'b0;
    expect_at(cyc, K_IRQ, 0, "R4 global gate");
    wait_edge(k0 + 210);
    gie = 1'b1; irq_en = 1'b0;
    expect_at(cyc, K_IRQ, 0, "R4 local gate");
    wait_edge(k0 + 220);
    irq_en = 1'b1;
    expect_at(cyc, K_IRQ, 1, "R4");

    // software clear, then clear colliding with a time-out
    expect_at(k0 + 700, K_TMO, 0, "R8 sw clear");
    write_at(k0 + 700, word(0, 1, 0, 0, 0, 1));
    expect_at(k0 + 767, K_TMO, 0, "R8");
    expect_at(k0 + 768, K_TMO, 1, "R8 hw set wins");
    write_at(k0 + 768, word(0, 1, 0, 0, 0, 1));

    // R11 select change keeps the count
    k1 = k0 + 800;
    write_at(k1, word(1, 1, 0, 1, 0, 1));
    expect_at(k1 + 200, K_TMO, 0, "R11");
    expect_at(k1 + 201, K_TMO, 1, "R11");
    write_at(k1 + 200, word(0, 1, 1, 0, 0, 1));

    // R2 remaining periods
    for (int s = 1; s < 4; s++) begin
      k = cyc + 5;
      expect_at(k + per(s) - 1, K_TMO, 0, "R2 period");
      expect_at(k + per(s),     K_TMO, 1, "R2 period");
      write_at(k, word(s, 1, 0, 1, 0, 1));
      wait_edge(k + per(s) + 2);
    end

    // R5/R6 grace window and own reset
    k = cyc + 5;
    expect_at(k + 1024, K_TMO, 1, "R5 flag");
    expect_at(k + 1023 + GRACE, K_RST, 0, "R5");
    expect_at(k + 1024 + GRACE, K_RST, 1, "R5 pulse");
    expect_at(k + 1025 + GRACE, K_RST, 0, "R5 single");
    expect_at(k + 1023 + GRACE, K_CAUSE, 0, "R6");
    expect_at(k + 1024 + GRACE, K_CAUSE, 1, "R6 cause set");
    expect_at(k + 1024 + GRACE, K_TMO, 0, "R6 flag cleared");
    expect_at(k + 1025 + GRACE, K_RUN, 1, "R6 stays enabled");
    expect_at(k + 2559, K_TMO, 0, "R6 restart");
    expect_at(k + 2560, K_TMO, 1, "R6 restart");
    write_at(k, word(1, 1, 0, 1, 1, 1));

    // R3 restart inside the window
    expect_at(k + 3072, K_RST,   0, "R3 restart in window");
    expect_at(k + 3072, K_CAUSE, 1, "R6 sticky");
    write_at(k + 2860, word(1, 1, 1, 1, 1, 1));

    // R9 other reset
    e = k + 3200;
    expect_at(e, K_TMO,  0, "R9 flag");
    expect_at(e, K_WORD, int'(word(1, 1, 0, 0, 1, 1)), "R9 keeps control");
    expect_at(e + 1023, K_TMO, 1 - 1, "R9 count restarted");
    expect_at(e + 1024, K_TMO, 1, "R9");
    expect_at(k + 4396, K_RST, 0, "R9 window restarted");
    expect_at(e + 1024 + GRACE, K_RST, 1, "R9");
    ext_at(e);

    // R10 power-fail
    p = e + 1600;
    expect_at(p, K_WORD, 0, "R10");
    expect_at(p + 1600, K_TMO, 0, "R10 disabled");
    expect_at(p + 1600, K_RST, 0, "R10 disabled");
    pfail_at(p);
    wait_edge(p + 1602);

    // R8 cause flag software rules
    q = cyc + 5;
    write_at(q, word(0, 1, 1, 1, 1, 1));
    expect_at(q + 128 + GRACE, K_RST,   1, "R5 code00");
    expect_at(q + 128 + GRACE, K_CAUSE, 1, "R6");
    expect_at(q + 700, K_CAUSE, 1, "R8 write-1 keeps cause");
    write_at(q + 700, word(0, 1, 1, 0, 1, 1));
    expect_at(q + 710, K_CAUSE, 0, "R8 cause clear");
    write_at(q + 710, word(0, 0, 1, 0, 1, 1));
    write_at(q + 720, word(0, 1, 1, 0, 0, 0));

    wait_edge(q + 730);
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule